// File: doc/BRIEF.md
# Alternate-Byte Peripheral Transfer Sequencer

This block carries out a single move-to/from-peripheral operation. It is used by a processor with a wide data bus to reach byte-wide peripherals whose registers appear only at every second byte address. A data register, either 16 or 32 bits wide, is split into bytes and written out to memory, or it is assembled from bytes fetched from memory. Successive bytes sit two addresses apart. The most significant byte of the sized operand travels first.

A start strobe arrives with a 16-bit opcode and a 16-bit extension word. If the opcode is recognised, the block reads the selected address register and data register through a small register-file read port. The first byte address is the address register plus the sign-extended extension word. The block then issues one byte request per byte over a request/acknowledge memory interface, holding each request until it is acknowledged. When loading, it writes the assembled data register back in the same cycle as its done pulse.

If the opcode does not match, or the enable strap is low, the block raises a one-cycle not-handled flag and makes no memory access.

Top module: `alt_byte_xfer_seq`

## Requirements
- R1: An opcode is accepted only when (opcode AND 0xF138) equals 0x0108. On a start with any other opcode, `not_handled` is high for one cycle, starting the cycle after the start, and no memory request is made.
- R2: While `xfer_en` is low, every opcode is treated as not handled, exactly as in R1.
- R3: Opcode bit 6 sets the size. A value of 1 transfers four bytes and a value of 0 transfers two bytes.
- R4: Opcode bit 7 sets the direction. A value of 1 writes the data register's bytes to memory with `mem_we`=1. A value of 0 reads bytes with `mem_we`=0.
- R5: Opcode bits 2:0 select the address register (`rf_areg_sel`). Opcode bits 11:9 select the data register (`rf_dreg_sel`), and the same register is the writeback target (`rf_wr_sel`).
- R6: The first byte address is the address register plus the 16-bit extension word sign-extended to 32 bits. The sum wraps modulo 2^32. The address register is never written.
- R7: Bytes move from the most significant byte of the sized operand down to byte 0. The address increases by 2 between successive bytes, wrapping modulo 2^32.
- R8: On a load, each fetched byte replaces its byte lane in the data register, and all other bits keep their value. In the two-byte form, bits 31:16 are returned unchanged.
- R9: Each byte request keeps its address, write enable and write data steady until `mem_ack`. Read data is taken in the acknowledge cycle.
- R10: `done` is high for exactly one cycle, the cycle after the last byte is acknowledged. In that same cycle, `rf_wr_en` is high only for a load.
- R11: A start that arrives while a transfer is in progress is ignored.
- R12: A start that arrives in the cycle in which `done` is high is accepted, and its first request appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_en | input | 1 | Enable strap for the operation |
| start | input | 1 | Start strobe, sampled while idle |
| opcode | input | 16 | Operation word |
| ext_word | input | 16 | Signed displacement |
| rf_areg_sel | output | 3 | Address register read select |
| rf_areg_val | input | 32 | Address register value |
| rf_dreg_sel | output | 3 | Data register read select |
| rf_dreg_val | input | 32 | Data register value |
| rf_wr_en | output | 1 | Data register write strobe |
| rf_wr_sel | output | 3 | Data register write select |
| rf_wr_data | output | 32 | Data register write value |
| mem_req | output | 1 | Byte request |
| mem_addr | output | 32 | Byte address |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request acknowledge |
| mem_rdata | input | 8 | Read byte, valid with acknowledge |
| done | output | 1 | Completion pulse |
| not_handled | output | 1 | Opcode refused |

## Verification
The completion pulse and writeback of one transfer can coincide with the acceptance of the next start. The bench raises `start` with a new opcode exactly in the cycle where it sees `done`. It then judges that a request to the new start address is present in the following cycle, and that both transfers deliver their own full results. A start pulse placed in the middle of a transfer is also checked: the first transfer must finish with its own byte count, addresses and writeback, with no trace of the intruding opcode.

// File: rtl/abx_pkg.sv
package abx_pkg;
  localparam int unsigned SEL_W = 3;
  localparam logic [15:0] OP_MASK  = 16'hF138;
  localparam logic [15:0] OP_MATCH = 16'h0108;

  typedef enum logic [0:0] {ST_IDLE, ST_XFER} abx_state_t;

  typedef struct packed {
    logic             hit;
    logic             to_mem;
    logic             wide;
    logic [SEL_W-1:0] a_sel;
    logic [SEL_W-1:0] d_sel;
  } abx_dec_t;
endpackage

// File: rtl/abx_decode.sv
module abx_decode
  import abx_pkg::*;
(
  input  logic [15:0] op,
  input  logic        en,
  output abx_dec_t    dec
);
  always_comb begin
    dec.hit    = en && ((op & OP_MASK) == OP_MATCH);
    dec.to_mem = op[7];
    dec.wide   = op[6];
    dec.a_sel  = op[2:0];
    dec.d_sel  = op[11:9];
  end
endmodule

// File: rtl/abx_addr_gen.sv
module abx_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 16,
  parameter int unsigned STRIDE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_sx;
  logic [ADDR_W-1:0] addr_q;

  assign disp_sx = {{EXT_W{disp[DISP_W-1]}}, disp};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= base + disp_sx;
    end else if (step) begin
      addr_q <= addr_q + ADDR_W'(STRIDE);
    end
  end

  assign addr = addr_q;

  p_step_by_stride_r7: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (addr == $past(addr) + ADDR_W'(STRIDE)));
endmodule

// File: rtl/abx_lane.sv
module abx_lane #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [DATA_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] new_byte,
  output logic [BYTE_W-1:0] cur_byte,
  output logic [DATA_W-1:0] merged
);
  always_comb begin
    cur_byte = word[idx*BYTE_W +: BYTE_W];
    merged   = word;
    merged[idx*BYTE_W +: BYTE_W] = new_byte;
  end
endmodule

// File: rtl/alt_byte_xfer_seq.sv
module alt_byte_xfer_seq
  import abx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DISP_W = 16,
  parameter int unsigned STRIDE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_en,
  input  logic              start,
  input  logic [15:0]       opcode,
  input  logic [DISP_W-1:0] ext_word,
  output logic [2:0]        rf_areg_sel,
  input  logic [ADDR_W-1:0] rf_areg_val,
  output logic [2:0]        rf_dreg_sel,
  input  logic [DATA_W-1:0] rf_dreg_val,
  output logic              rf_wr_en,
  output logic [2:0]        rf_wr_sel,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              done,
  output logic              not_handled
);
  localparam int unsigned NBYTES = DATA_W / BYTE_W;
  localparam int unsigned IDX_W  = $clog2(NBYTES);
  localparam logic [IDX_W-1:0] LAST_LONG = IDX_W'(NBYTES - 1);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(NBYTES / 2 - 1);

  abx_dec_t          dec;
  abx_state_t        state_q;
  logic [IDX_W-1:0]  cnt_q;
  logic [DATA_W-1:0] data_q;
  logic              store_q;
  logic [2:0]        dsel_q;
  logic              done_q;
  logic              wr_q;
  logic              nh_q;
  logic              idle;
  logic              accept;
  logic              reject;
  logic              beat;
  logic              last;
  logic [BYTE_W-1:0] cur_byte;
  logic [DATA_W-1:0] merged;

  abx_decode u_dec (
    .op  (opcode),
    .en  (xfer_en),
    .dec (dec)
  );

  assign idle   = (state_q == ST_IDLE);
  assign accept = idle && start && dec.hit;
  assign reject = idle && start && !dec.hit;
  assign beat   = (state_q == ST_XFER) && mem_ack;
  assign last   = (cnt_q == '0);

  abx_addr_gen #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .STRIDE (STRIDE)
  ) u_addr (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .step (beat && !last),
    .base (rf_areg_val),
    .disp (ext_word),
    .addr (mem_addr)
  );

  abx_lane #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .IDX_W  (IDX_W)
  ) u_lane (
    .word     (data_q),
    .idx      (cnt_q),
    .new_byte (mem_rdata),
    .cur_byte (cur_byte),
    .merged   (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      data_q  <= '0;
      store_q <= 1'b0;
      dsel_q  <= '0;
      done_q  <= 1'b0;
      wr_q    <= 1'b0;
      nh_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      nh_q   <= reject;
      if (accept) begin
        state_q <= ST_XFER;
        cnt_q   <= dec.wide ? LAST_LONG : LAST_WORD;
        data_q  <= rf_dreg_val;
        store_q <= dec.to_mem;
        dsel_q  <= dec.d_sel;
      end else if (beat) begin
        if (!store_q) begin
          data_q <= merged;
        end
        if (last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          wr_q    <= !store_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign rf_areg_sel = dec.a_sel;
  assign rf_dreg_sel = dec.d_sel;
  assign rf_wr_en    = wr_q;
  assign rf_wr_sel   = dsel_q;
  assign rf_wr_data  = data_q;
  assign mem_req     = (state_q == ST_XFER);
  assign mem_we      = store_q;
  assign mem_wdata   = cur_byte;
  assign done        = done_q;
  assign not_handled = nh_q;

  p_hold_request_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_writeback_with_done_r10: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> (done && !mem_req));

  p_refused_no_access_r1: assert property (@(posedge clk) disable iff (rst)
    not_handled |-> (!mem_req && !done));

  p_busy_ignores_start_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> !not_handled);
endmodule

// File: tb/sim_alt_byte_xfer_seq.sv
module sim_alt_byte_xfer_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xfer_en = 1'b1;
  logic        start = 1'b0;
  logic [15:0] opcode = '0;
  logic [15:0] ext_word = '0;
  logic [2:0]  rf_areg_sel, rf_dreg_sel, rf_wr_sel;
  logic [31:0] rf_areg_val, rf_dreg_val, rf_wr_data;
  logic        rf_wr_en;
  logic        mem_req, mem_we, done, not_handled;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = '0;

  logic [31:0] aregs [8];
  logic [31:0] dregs [8];
  logic [7:0]  mem [256];
  logic [31:0] log_addr [8];
  logic [7:0]  log_wd [8];
  int          log_n = 0;
  int          wait_cnt = 0;
  int          dly_seed = 0;
  int          checks = 0;
  int          errors = 0;

  assign rf_areg_val = aregs[rf_areg_sel];
  assign rf_dreg_val = dregs[rf_dreg_sel];

  always #(CLK_PERIOD/2) clk = ~clk;

  alt_byte_xfer_seq u0 (
    .clk(clk), .rst(rst), .xfer_en(xfer_en), .start(start), .opcode(opcode),
    .ext_word(ext_word), .rf_areg_sel(rf_areg_sel), .rf_areg_val(rf_areg_val),
    .rf_dreg_sel(rf_dreg_sel), .rf_dreg_val(rf_dreg_val), .rf_wr_en(rf_wr_en),
    .rf_wr_sel(rf_wr_sel), .rf_wr_data(rf_wr_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
    .not_handled(not_handled)
  );

  // Memory responder with 0..2 wait cycles
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_ack   = 1'b1;
        mem_rdata = mem[mem_addr[7:0]];
        if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
        if (log_n < 8) begin
          log_addr[log_n] = mem_addr;
          log_wd[log_n]   = mem_wdata;
        end
        log_n++;
        dly_seed++;
        wait_cnt = dly_seed % 3;
      end else begin
        wait_cnt--;
      end
    end
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic init_mem();
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_op(input int dn, input int an,
                                         input bit st, input bit lg);
    return 16'h0108 | 16'(dn << 9) | 16'(st << 7) | 16'(lg << 6) | 16'(an);
  endfunction

  task automatic pulse_start(input logic [15:0] op, input logic [15:0] ext);
    @(negedge clk);
    log_n = 0;
    opcode = op; ext_word = ext; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // Checks the outcome at the negedge where done is expected high
  task automatic verify(input int dn, input bit st, input bit lg,
                        input logic [15:0] ext, input logic [31:0] aval,
                        input logic [31:0] dval);
    int n = lg ? 4 : 2;
    logic [31:0] sa = aval + {{16{ext[15]}}, ext};
    logic [31:0] exp = dval;
    chk(done === 1'b1, "R10", 32'(done), 32'd1);
    chk(log_n == n, "R3", 32'(log_n), 32'(n));
    for (int k = 0; k < n; k++) begin
      chk(log_addr[k] == sa + 32'(2 * k), "R7", log_addr[k], sa + 32'(2 * k));
      if (st) begin
        chk(log_wd[k] == dval[(n-1-k)*8 +: 8], "R4", 32'(log_wd[k]),
            32'(dval[(n-1-k)*8 +: 8]));
        chk(mem[(sa[7:0] + 8'(2*k + 1))] == pat(int'(sa[7:0]) + 2*k + 1), "R4",
            32'(mem[(sa[7:0] + 8'(2*k + 1))]), 32'(pat(int'(sa[7:0]) + 2*k + 1)));
      end else begin
        exp[(n-1-k)*8 +: 8] = pat(int'(sa[7:0] + 8'(2 * k)));
      end
    end
    if (st) begin
      chk(rf_wr_en === 1'b0, "R10", 32'(rf_wr_en), 32'd0);
    end else begin
      chk(rf_wr_en === 1'b1 && rf_wr_sel == 3'(dn), "R5", {28'd0, rf_wr_en, rf_wr_sel},
          {28'd0, 1'b1, 3'(dn)});
      chk(rf_wr_data == exp, "R8", rf_wr_data, exp);
    end
    @(negedge clk);
    chk(done === 1'b0 && rf_wr_en === 1'b0, "R10", {30'd0, done, rf_wr_en}, 32'd0);
  endtask

  task automatic run_op(input int dn, input int an, input bit st, input bit lg,
                        input logic [15:0] ext, input logic [31:0] aval,
                        input logic [31:0] dval);
    aregs[an] = aval;
    dregs[dn] = dval;
    init_mem();
    pulse_start(mk_op(dn, an, st, lg), ext);
    wait_done();
    verify(dn, st, lg, ext, aval, dval);
  endtask

  task automatic refuse(input logic [15:0] op, input string req);
    init_mem();
    pulse_start(op, 16'h0000);
    chk(not_handled === 1'b1, req, 32'(not_handled), 32'd1);
    @(negedge clk);
    chk(not_handled === 1'b0 && mem_req === 1'b0 && log_n == 0, req,
        {30'd0, not_handled, mem_req}, 32'd0);
    repeat (3) @(negedge clk);
    chk(log_n == 0 && done === 1'b0, req, 32'(log_n), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      aregs[i] = '0;
      dregs[i] = '0;
    end
    init_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    chk(!done && !mem_req && !not_handled && !rf_wr_en, "R10",
        {28'd0, done, mem_req, not_handled, rf_wr_en}, 32'd0);

    // Sweep all register pairs, sizes and directions (R3 R4 R5 R6 R7 R8 R9)
    for (int dn = 0; dn < 8; dn++) begin
      for (int an = 0; an < 8; an++) begin
        for (int m = 0; m < 4; m++) begin
          logic [15:0] ext = (an % 2 == 1) ? 16'(-(an * 3 + 1)) : 16'(an * 5 + m);
          logic [31:0] aval = 32'h0000_0080 + 32'(an * 7);
          logic [31:0] dval = 32'hA1B2_C3D4 ^ (32'h0101_0101 * 32'(dn * 5 + m));
          run_op(dn, an, m[1], m[0], ext, aval, dval);
        end
      end
    end

    // R6: wrap across 2^32, negative displacement
    run_op(2, 5, 1'b0, 1'b1, 16'h0002, 32'hFFFF_FFFC, 32'h1234_5678);
    run_op(3, 1, 1'b1, 1'b1, 16'hFFF8, 32'h0000_0010, 32'hCAFE_F00D);
    run_op(6, 7, 1'b0, 1'b0, 16'h8000, 32'h0000_8020, 32'h9988_7766);

    // R1: opcodes that miss the pattern
    refuse(16'h0100, "R1");
    refuse(16'h1108, "R1");
    refuse(16'h0118, "R1");
    refuse(16'h0008, "R1");
    refuse(16'h0148 | 16'h0030, "R1");

    // R2: strap low refuses a valid opcode
    xfer_en = 1'b0;
    refuse(mk_op(1, 2, 1'b0, 1'b1), "R2");
    xfer_en = 1'b1;

    // R11: start during a transfer is ignored
    aregs[4] = 32'h0000_0040;
    dregs[5] = 32'h0F0E_0D0C;
    dregs[0] = 32'h5555_5555;
    init_mem();
    pulse_start(mk_op(5, 4, 1'b0, 1'b1), 16'h0004);
    opcode = mk_op(0, 4, 1'b1, 1'b0); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(not_handled === 1'b0, "R11", 32'(not_handled), 32'd0);
    wait_done();
    verify(5, 1'b0, 1'b1, 16'h0004, 32'h0000_0040, 32'h0F0E_0D0C);

    // R12: start accepted in the done cycle
    aregs[3] = 32'h0000_0060;
    dregs[7] = 32'hDEAD_BEEF;
    aregs[6] = 32'h0000_00A0;
    dregs[2] = 32'h0102_0304;
    init_mem();
    pulse_start(mk_op(7, 3, 1'b1, 1'b0), 16'h0000);
    wait_done();
    chk(done === 1'b1 && log_n == 2, "R12", 32'(log_n), 32'd2);
    log_n = 0;
    opcode = mk_op(2, 6, 1'b0, 1'b1); ext_word = 16'h0010; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mem_req === 1'b1 && mem_addr == 32'h0000_00B0 && mem_we === 1'b0, "R12",
        mem_addr, 32'h0000_00B0);
    wait_done();
    verify(2, 1'b0, 1'b1, 16'h0010, 32'h0000_00A0, 32'h0102_0304);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule